// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds the one-time-programmable identification and security words of a nonvolatile memory, along with the lock registers that protect them. A host issues commands on a small interface. Each command carries a two-bit operation code, a word address and a 16-bit data word. A program updates one 16-bit word using one-time-programmable rules: a bit can change from 1 to 0 but never back. A 64-bit region therefore needs four programs and a 128-bit region needs eight.

The storage has three parts. The first 128-bit register is split into a lower half written at the factory and an upper half the user can write. Sixteen further 128-bit registers belong to the user. Two 16-bit lock registers complete the set, and every lock bit guards one region. A status byte reports readiness and sticky error flags. A registered read port returns any stored word or either lock register.

Top module: `otp_guard`

## Requirements
- R1: After reset, status reads 0x80 (ready, no errors). Every data word reads 0xFFFF. The lock register at 0x80 reads 0xFFFE and the lock register at 0x89 reads 0xFFFF.
- R2: Operation code 2'b01 (program word) to an unlocked in-window address replaces the stored word with old AND data.
- R3: The data words sit at these addresses: 0x81–0x84 is the factory half of register 0, 0x85–0x88 is the user half, and upper register n (0–15) occupies 0x8A+8n through 0x8A+8n+7. A program word command to any other address leaves storage unchanged and sets status bit 4.
- R4: A program word command to a locked word leaves it unchanged and sets status bits 4 and 1. The factory half is always locked.
- R5: Operation code 2'b10 (program lock) at 0x89 ANDs all 16 data bits into that lock register. At 0x80 it ANDs only data bit 1 into bit 1, while bit 0 stays 0 and bits 15:2 stay 1. At any other address it sets status bit 4 and changes nothing.
- R6: A lock bit at 0 locks its region. Bit 1 of the register at 0x80 guards the user half of register 0. Bit n of the register at 0x89 guards upper register n and no other.
- R7: A lock bit that has gone to 0 never returns to 1.
- R8: Status bit 7 (ready) drops for exactly BUSY_CYCLES cycles after an accepted program. A rejected command leaves ready high. Any command presented while ready is low is ignored.
- R9: Status bits 4 and 1 stay set until clr_status is pulsed. If an error is set in the same cycle as a clear, the new error remains set. All other status bits read 0.
- R10: rd_data shows, one cycle after rd_addr is presented, the word at an in-window address, the lock register at 0x80 or 0x89, or 0 elsewhere. A word written in that same cycle is shown at its old value.
- R11: Operation codes 2'b00 and 2'b11 have no effect on storage, locks, ready or errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | AW | Command word address |
| cmd_data | input | 16 | Program data |
| clr_status | input | 1 | Clears the error flags |
| rd_addr | input | AW | Read word address |
| rd_data | output | 16 | Registered read data |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
The bench builds the block with BUSY_CYCLES set to 3 and AW left at 10. The short busy window lets the run fit many program and lock sequences, and it makes the exact length of the busy interval easy to count. It also lets the bench present a second command while the block is still busy. Because AW is 10, every address from 0x000 upward can be driven, so the run reaches the word just below the first data word, the gap at 0x89 and the first address past 0x109.

// File: rtl/otp_guard.sv
`timescale 1ns/1ps
module otp_guard #(
  parameter int BUSY_CYCLES = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [15:0]   cmd_data,
  input  logic          clr_status,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic [7:0]    status
);
  localparam int NREGS  = 16;
  localparam int NWORDS = 8 + NREGS * 8;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam logic [1:0] OP_WORD = 2'b01;
  localparam logic [1:0] OP_LOCK = 2'b10;
  localparam logic [AW-1:0] A_LK0   = AW'('h80);
  localparam logic [AW-1:0] A_FAC   = AW'('h81);
  localparam logic [AW-1:0] A_R0END = AW'('h88);
  localparam logic [AW-1:0] A_LK1   = AW'('h89);
  localparam logic [AW-1:0] A_UPR   = AW'('h8A);
  localparam logic [AW-1:0] A_UEND  = AW'(A_UPR + AW'(NREGS * 8 - 1));

  logic [15:0] mem_q [NWORDS];
  logic [15:0] lock0_q, lock1_q;
  logic [CNT_W-1:0] busy_q;
  logic err_pgm_q, err_lck_q;

  function automatic logic in_win(logic [AW-1:0] a);
    return (a >= A_FAC && a <= A_R0END) || (a >= A_UPR && a <= A_UEND);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(logic [AW-1:0] a);
    return (a <= A_R0END) ? IDX_W'(a - A_FAC) : IDX_W'(a - A_FAC - AW'(1));
  endfunction

  function automatic logic [3:0] reg_of(logic [IDX_W-1:0] i);
    return 4'((i - IDX_W'(8)) >> 3);
  endfunction

  function automatic logic guarded(logic [IDX_W-1:0] i, logic [15:0] l0, logic [15:0] l1);
    if (i < IDX_W'(4)) return !l0[0];
    if (i < IDX_W'(8)) return !l0[1];
    return !l1[reg_of(i)];
  endfunction

  wire ready    = (busy_q == '0);
  wire take     = cmd_valid && ready;
  wire is_word  = take && cmd_op == OP_WORD;
  wire is_lock  = take && cmd_op == OP_LOCK;
  wire c_in     = in_win(cmd_addr);
  wire [IDX_W-1:0] c_idx = to_idx(cmd_addr);
  wire c_lkd    = guarded(c_idx, lock0_q, lock1_q);
  wire word_ok  = is_word && c_in && !c_lkd;
  wire word_lkd = is_word && c_in && c_lkd;
  wire word_oow = is_word && !c_in;
  wire lk0_ok   = is_lock && cmd_addr == A_LK0;
  wire lk1_ok   = is_lock && cmd_addr == A_LK1;
  wire lock_bad = is_lock && !lk0_ok && !lk1_ok;
  wire start    = word_ok || lk0_ok || lk1_ok;

  wire r_in = in_win(rd_addr);
  wire [IDX_W-1:0] r_idx = to_idx(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem_q[i] <= '1;
      lock0_q   <= 16'hFFFE;
      lock1_q   <= 16'hFFFF;
      busy_q    <= '0;
      err_pgm_q <= 1'b0;
      err_lck_q <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (word_ok) mem_q[c_idx] <= mem_q[c_idx] & cmd_data;
      if (lk0_ok)  lock0_q <= lock0_q & {14'h3FFF, cmd_data[1], 1'b1};
      if (lk1_ok)  lock1_q <= lock1_q & cmd_data;

      if (start)        busy_q <= CNT_W'(BUSY_CYCLES);
      else if (!ready)  busy_q <= busy_q - CNT_W'(1);

      if (word_oow || word_lkd || lock_bad) err_pgm_q <= 1'b1;
      else if (clr_status)                  err_pgm_q <= 1'b0;
      if (word_lkd)        err_lck_q <= 1'b1;
      else if (clr_status) err_lck_q <= 1'b0;

      if (r_in)                 rd_data <= mem_q[r_idx];
      else if (rd_addr == A_LK0) rd_data <= lock0_q;
      else if (rd_addr == A_LK1) rd_data <= lock1_q;
      else                      rd_data <= '0;
    end
  end

  assign status = {ready, 2'b00, err_pgm_q, 2'b00, err_lck_q, 1'b0};
endmodule

// File: rtl/otp_guard_chk.sv
`timescale 1ns/1ps
module otp_guard_chk #(
  parameter int BUSY_CYCLES = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             clr_status,
  input logic [7:0]       status,
  input logic [15:0]      lock0_q,
  input logic [15:0]      lock1_q,
  input logic [CNT_W-1:0] busy_q
);
  // R8
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(cmd_valid));

  // R8
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(busy_q) <= BUSY_CYCLES);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] && cmd_valid) |=> ($stable(lock0_q) && $stable(lock1_q)));

  // R9
  pgm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(clr_status));

  // R9
  lck_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(clr_status));

  // R4
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[4]);

  // R7
  lock_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock0_q & ~$past(lock0_q)) == 16'h0) && ((lock1_q & ~$past(lock1_q)) == 16'h0));

  // R5
  lock0_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock0_q[0] && (&lock0_q[15:2]));

  // R11
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status[7] && (cmd_op == 2'b00 || cmd_op == 2'b11)) |=> status[7]);
endmodule

bind otp_guard otp_guard_chk #(.BUSY_CYCLES(BUSY_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .clr_status(clr_status), .status(status), .lock0_q(lock0_q),
  .lock1_q(lock1_q), .busy_q(busy_q)
);

// File: tb/sim_otp_guard.sv
`timescale 1ns/1ps
module sim_otp_guard;
  localparam int B = 3;
  logic clk = 0, rst_n = 0, cmd_valid = 0, clr_status = 0;
  logic [1:0] cmd_op = 0;
  logic [9:0] cmd_addr = 0, rd_addr = 0;
  logic [15:0] cmd_data = 0;
  logic [15:0] rd_data;
  logic [7:0] status;
  int checks = 0, fails = 0;
  bit cmp_en = 0, done = 0;

  always #4 clk = ~clk;

  otp_guard #(.BUSY_CYCLES(B), .AW(10)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .clr_status(clr_status),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status));

  // behavioural reference model
  int m_mem[136];
  int m_lk0, m_lk1, m_cnt, m_rd;
  bit m_ep, m_el;

  function automatic bit m_in(int a);
    return (a >= 129 && a <= 136) || (a >= 138 && a <= 265);
  endfunction
  function automatic int m_idx(int a);
    return (a <= 136) ? a - 129 : a - 130;
  endfunction
  function automatic bit m_locked(int i);
    if (i < 4) return (m_lk0 & 1) == 0;
    if (i < 8) return ((m_lk0 >> 1) & 1) == 0;
    return ((m_lk1 >> ((i - 8) / 8)) & 1) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 'hFFFF;
      m_lk0 = 'hFFFE; m_lk1 = 'hFFFF; m_cnt = 0; m_ep = 0; m_el = 0; m_rd = 0;
    end else begin
      int a, d;
      bit rdy, e_p, e_l;
      a = int'(rd_addr);
      if (m_in(a)) m_rd = m_mem[m_idx(a)];
      else if (a == 128) m_rd = m_lk0;
      else if (a == 137) m_rd = m_lk1;
      else m_rd = 0;
      a = int'(cmd_addr); d = int'(cmd_data);
      rdy = (m_cnt == 0);
      e_p = 0; e_l = 0;
      if (!rdy) m_cnt--;
      if (cmd_valid && rdy) begin
        if (cmd_op == 2'b01) begin
          if (!m_in(a)) e_p = 1;
          else if (m_locked(m_idx(a))) begin e_p = 1; e_l = 1; end
          else begin m_mem[m_idx(a)] = m_mem[m_idx(a)] & d; m_cnt = B; end
        end else if (cmd_op == 2'b10) begin
          if (a == 128) begin m_lk0 = m_lk0 & (d | 'hFFFD); m_cnt = B; end
          else if (a == 137) begin m_lk1 = m_lk1 & d; m_cnt = B; end
          else e_p = 1;
        end
      end
      if (clr_status) begin m_ep = 0; m_el = 0; end
      if (e_p) m_ep = 1;
      if (e_l) m_el = 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) begin
    logic [7:0] es;
    es = {m_cnt == 0, 2'b00, m_ep, 2'b00, m_el, 1'b0};
    chk(status === es, "R8 R9 status vs model", int'(status), int'(es));
    chk(rd_data === 16'(m_rd), "R10 rd_data vs model", int'(rd_data), m_rd);
  end

  task automatic cmd(logic [1:0] op, int a, int d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = 10'(a); cmd_data = 16'(d);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_rdy();
    while (!status[7]) @(negedge clk);
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk); rd_addr = 10'(a);
    @(negedge clk);
    chk(rd_data === 16'(exp), tag, int'(rd_data), exp);
  endtask

  task automatic st(int exp, string tag);
    chk(status === 8'(exp), tag, int'(status), exp);
  endtask

  task automatic clr();
    @(negedge clk); clr_status = 1;
    @(negedge clk); clr_status = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;
    // R1 reset state
    st('h80, "R1 status after reset");
    rd('h81, 'hFFFF, "R1 factory word erased");
    rd('h109, 'hFFFF, "R1 last word erased");
    rd('h80, 'hFFFE, "R1 lock0 reset");
    rd('h89, 'hFFFF, "R1 lock1 reset");
    // R2 program and busy length R8
    cmd(2'b01, 'h85, 'h1234);
    n = 0;
    while (!status[7]) begin n++; @(negedge clk); end
    chk(n == B, "R8 busy length", n, B);
    rd('h85, 'h1234, "R2 first program");
    cmd(2'b01, 'h85, 'hFF0F); wait_rdy();
    rd('h85, 'h1204, "R2 AND semantics");
    // R3 map
    cmd(2'b01, 'hA4, 'h00FF); wait_rdy();
    rd('hA4, 'h00FF, "R3 upper reg 3 word 2");
    rd('hA3, 'hFFFF, "R3 neighbour untouched");
    cmd(2'b01, 'h109, 'hABCD); wait_rdy();
    rd('h109, 'hABCD, "R3 last word");
    cmd(2'b01, 'h10A, 'h0000);
    st('h90, "R3 out of window above, R8 no busy");
    clr();
    st('h80, "R9 clear");
    cmd(2'b01, 'h89, 'h0000);
    st('h90, "R3 gap at 0x89");
    cmd(2'b01, 'h80, 'h0000);
    cmd(2'b01, 'h000, 'h0000);
    rd('h80, 'hFFFE, "R3 lock0 unchanged by word program");
    // R9 clear with simultaneous error
    @(negedge clk);
    clr_status = 1; cmd_valid = 1; cmd_op = 2'b01; cmd_addr = 10'h10A; cmd_data = 0;
    @(negedge clk);
    clr_status = 0; cmd_valid = 0;
    st('h90, "R9 error wins over clear");
    clr();
    // R4 factory half locked
    cmd(2'b01, 'h82, 'h0000);
    st('h92, "R4 factory locked");
    rd('h82, 'hFFFF, "R4 factory word unchanged");
    clr();
    // R5 R6 lock upper reg 3
    cmd(2'b10, 'h89, 'hFFF7); wait_rdy();
    rd('h89, 'hFFF7, "R5 lock1 program");
    cmd(2'b01, 'hA4, 'h0000);
    st('h92, "R6 reg 3 locked");
    rd('hA4, 'h00FF, "R6 locked word unchanged");
    clr();
    cmd(2'b01, 'hAA, 'h5555); wait_rdy();
    rd('hAA, 'h5555, "R6 reg 4 still open");
    // R5 lock0 only bit 1
    cmd(2'b10, 'h80, 'h0000); wait_rdy();
    rd('h80, 'hFFFC, "R5 lock0 unused bits");
    cmd(2'b01, 'h86, 'h0000);
    st('h92, "R6 user half locked");
    clr();
    // R7 irreversible
    cmd(2'b10, 'h89, 'hFFFF); wait_rdy();
    rd('h89, 'hFFF7, "R7 lock1 stays");
    cmd(2'b10, 'h80, 'hFFFF); wait_rdy();
    rd('h80, 'hFFFC, "R7 lock0 stays");
    cmd(2'b10, 'h85, 'h0000);
    st('h90, "R5 lock op bad address");
    clr();
    // R11 unused codes
    cmd(2'b00, 'h87, 'h0000);
    st('h80, "R11 op 00 no effect");
    cmd(2'b11, 'h87, 'h0000);
    st('h80, "R11 op 11 no effect");
    rd('h87, 'hFFFF, "R11 word unchanged");
    // R8 command while busy ignored (0x87 locked now, use upper reg 5)
    cmd(2'b01, 'hB2, 'h0000);
    cmd(2'b01, 'hB3, 'h0000);
    wait_rdy();
    rd('hB3, 'hFFFF, "R8 busy command ignored");
    rd('hB2, 'h0000, "R8 first command done");
    // R10 read during write
    @(negedge clk);
    rd_addr = 10'h8B; cmd_valid = 1; cmd_op = 2'b01; cmd_addr = 10'h8B; cmd_data = 16'h0F0F;
    @(negedge clk);
    cmd_valid = 0;
    chk(rd_data === 16'hFFFF, "R10 old value same cycle", int'(rd_data), 'hFFFF);
    @(negedge clk);
    chk(rd_data === 16'h0F0F, "R10 new value next cycle", int'(rd_data), 'h0F0F);
    rd('h00, 'h0000, "R10 out of window reads zero");
    wait_rdy();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule